// File: doc/BRIEF.md
# Bus-Mapped GPIO Port Controller

This block is one general-purpose I/O port that sits on a simple synchronous register bus. Software sets a direction for each pin and writes output values. It can update the whole port at once, update only a chosen group of bits through a protection mask, or force individual bits high or low in one write without first reading the port. Each pad receives an output enable and an output value. The pad input levels pass through a two-flop synchronizer, and software can read them back.

A small interrupt unit provides up to eight channels. Each channel picks any one port pin through a selector. A channel can be programmed in two ways. As an edge channel it detects one edge, rising or falling, and latches the event in a status bit that stays set until cleared. As a level channel its status follows the pin's active level. One request line goes high whenever any enabled channel has its status set.

Bus writes take effect on the clock edge where `busSel` and `busWr` are both high. Reads are combinational from `busAddr`. Every register can be reached as a byte, half-word or word through the four byte-lane strobes.

Top module: `gpio_port_ctrl_top`

## Requirements
- R1: After reset the direction, output, mask, selector and channel configuration registers are all 0. `pinOe` and `pinOut` are 0 and `irq` is low.
- R2: The direction register is at word index 0. Bit value 1 makes that pin an output (`pinOe` high) and 0 makes it an input.
- R3: The output register is at index 1 and is read/write; `pinOut` mirrors it. A write to the set register at index 2 drives high every output bit whose data bit is 1. All other bits keep their value. Index 2 reads as 0.
- R4: A write to the clear register at index 3 drives low every output bit whose data bit is 1. All other bits keep their value. Index 3 reads as 0.
- R5: The mask register is at index 4. A write to the masked-port register at index 5 changes only those output bits whose mask bit is 0. A read of index 5 returns the synchronized pin levels with every masked bit forced to 0.
- R6: Each byte-lane strobe `busBe[k]` enables data bits 8k+7..8k of a write. Bytes whose strobe is low leave the target register unchanged. This holds for every register.
- R7: Index 6 returns the synchronized pin levels, which reflect `pinIn` within three clock edges. Index 1 returns the output register, independent of the pins.
- R8: Bits at or above the port width read as 0 and ignore writes.
- R9: Channel selectors are one byte per channel: channels 0 to 3 at index 7 and channels 4 to 7 at index 8, channel c in byte c mod 4. Each byte holds the source pin number in its low bits. Channels are configured at index 9: byte 0 is the enables, byte 1 the mode (1 = level, 0 = edge), byte 2 the polarity (1 = rising or high, 0 = falling or low).
- R10: An enabled edge channel sets its status bit at index 10 when its selected pin shows the programmed edge. The bit stays set until a write of 1 to that bit at index 10.
- R11: An enabled level channel's status bit equals 1 exactly while its selected pin is at the programmed level. A disabled channel's status stays 0.
- R12: `irq` is high while any enabled channel has its status bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | Write when high, read when low |
| busAddr | input | 4 | Word index of the register |
| busWdata | input | 32 | Write data |
| busBe | input | 4 | Byte-lane write strobes |
| busRdata | output | 32 | Read data for `busAddr` |
| pinIn | input | PORT_W | Pad input levels (asynchronous) |
| pinOe | output | PORT_W | Per-pin output enable |
| pinOut | output | PORT_W | Per-pin output value |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that a write names a single register index per cycle and that `pinIn` may change at any time. The asynchronous inputs are only relied on after the synchronizer.

The edge-sticky property assumes that enable, mode and selector stay steady while a status bit is being observed. The stimulus therefore reprograms channels first, then clears status, and only then toggles the pins. It changes pins half a cycle away from the clock and waits four cycles before reading back, so every synchronizer and detector stage has settled.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [3:0] {
    IDX_DIR   = 4'd0,
    IDX_OUT   = 4'd1,
    IDX_SET   = 4'd2,
    IDX_CLR   = 4'd3,
    IDX_MASK  = 4'd4,
    IDX_MPORT = 4'd5,
    IDX_PIN   = 4'd6,
    IDX_SEL0  = 4'd7,
    IDX_SEL1  = 4'd8,
    IDX_CFG   = 4'd9,
    IDX_STAT  = 4'd10
  } regIdx_e;

  typedef struct packed {
    logic        wrDir;
    logic        wrOut;
    logic        wrSet;
    logic        wrClr;
    logic        wrMask;
    logic        wrMport;
    logic        wrSel0;
    logic        wrSel1;
    logic        wrCfg;
    logic        wrStat;
    logic [31:0] laneMask;
  } wrStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic       busSel,
  input  logic       busWr,
  input  logic [3:0] busAddr,
  input  logic [3:0] busBe,
  output wrStrobe_t  stb
);

  logic wrEn;
  assign wrEn = busSel & busWr;

  always_comb begin
    stb = '0;
    for (int k = 0; k < 4; k++) begin
      stb.laneMask[8*k +: 8] = {8{busBe[k]}};
    end
    if (wrEn) begin
      case (regIdx_e'(busAddr))
        IDX_DIR:   stb.wrDir   = 1'b1;
        IDX_OUT:   stb.wrOut   = 1'b1;
        IDX_SET:   stb.wrSet   = 1'b1;
        IDX_CLR:   stb.wrClr   = 1'b1;
        IDX_MASK:  stb.wrMask  = 1'b1;
        IDX_MPORT: stb.wrMport = 1'b1;
        IDX_SEL0:  stb.wrSel0  = 1'b1;
        IDX_SEL1:  stb.wrSel1  = 1'b1;
        IDX_CFG:   stb.wrCfg   = 1'b1;
        IDX_STAT:  stb.wrStat  = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         stb,
  input  logic [3:0]        busAddr,
  input  logic [31:0]       busWdata,
  input  logic [PORT_W-1:0] pinIn,
  output logic [31:0]       busRdata,
  output logic [PORT_W-1:0] pinOe,
  output logic [PORT_W-1:0] pinOut,
  output logic              irq
);

  localparam int SEL_W = (PORT_W > 1) ? $clog2(PORT_W) : 1;
  localparam int PAD_W = 1 << SEL_W;

  logic [PORT_W-1:0] dirReg, outReg, maskReg;
  logic [PORT_W-1:0] syncA, pinSync;
  logic [PORT_W-1:0] laneW, wrW, mportLane;
  logic [PAD_W-1:0]  pinPad;
  logic [SEL_W-1:0]  chSel [NUM_CH];
  logic [NUM_CH-1:0] cfgEn, cfgLvl, cfgPol;
  logic [NUM_CH-1:0] srcVal, srcPrev, edgeStat, lvlStat, statVec, edgeEvt, clrBits;

  assign laneW     = stb.laneMask[PORT_W-1:0];
  assign wrW       = busWdata[PORT_W-1:0] & laneW;
  assign mportLane = laneW & ~maskReg;

  // Port registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      outReg  <= '0;
      maskReg <= '0;
    end else begin
      if (stb.wrDir)  dirReg  <= (dirReg & ~laneW) | wrW;
      if (stb.wrMask) maskReg <= (maskReg & ~laneW) | wrW;
      if (stb.wrOut)        outReg <= (outReg & ~laneW) | wrW;
      else if (stb.wrSet)   outReg <= outReg | wrW;
      else if (stb.wrClr)   outReg <= outReg & ~wrW;
      else if (stb.wrMport) outReg <= (outReg & ~mportLane) | (busWdata[PORT_W-1:0] & mportLane);
    end
  end

  // Input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      pinSync <= '0;
    end else begin
      syncA   <= pinIn;
      pinSync <= syncA;
    end
  end

  always_comb begin
    pinPad = '0;
    pinPad[PORT_W-1:0] = pinSync;
  end

  // Channel configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn  <= '0;
      cfgLvl <= '0;
      cfgPol <= '0;
      for (int c = 0; c < NUM_CH; c++) chSel[c] <= '0;
    end else begin
      if (stb.wrCfg && stb.laneMask[0])  cfgEn  <= busWdata[NUM_CH-1:0];
      if (stb.wrCfg && stb.laneMask[8])  cfgLvl <= busWdata[8 +: NUM_CH];
      if (stb.wrCfg && stb.laneMask[16]) cfgPol <= busWdata[16 +: NUM_CH];
      for (int c = 0; c < NUM_CH; c++) begin
        if (((c < 4) ? stb.wrSel0 : stb.wrSel1) && stb.laneMask[8*(c%4)])
          chSel[c] <= busWdata[8*(c%4) +: SEL_W];
      end
    end
  end

  // Per-channel detection
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gCh
      assign srcVal[g]  = pinPad[chSel[g]];
      assign edgeEvt[g] = cfgEn[g] & ~cfgLvl[g] &
                          (cfgPol[g] ? (srcVal[g] & ~srcPrev[g]) : (~srcVal[g] & srcPrev[g]));
      assign clrBits[g] = stb.wrStat & stb.laneMask[g] & busWdata[g];
      assign statVec[g] = cfgLvl[g] ? lvlStat[g] : edgeStat[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPrev  <= '0;
      edgeStat <= '0;
      lvlStat  <= '0;
    end else begin
      srcPrev  <= srcVal;
      edgeStat <= (edgeStat & ~clrBits) | edgeEvt;
      lvlStat  <= cfgEn & cfgLvl & ~(srcVal ^ cfgPol);
    end
  end

  assign irq    = |(statVec & cfgEn);
  assign pinOe  = dirReg;
  assign pinOut = outReg;

  // Read mux
  always_comb begin
    busRdata = '0;
    case (regIdx_e'(busAddr))
      IDX_DIR:   busRdata[PORT_W-1:0] = dirReg;
      IDX_OUT:   busRdata[PORT_W-1:0] = outReg;
      IDX_MASK:  busRdata[PORT_W-1:0] = maskReg;
      IDX_MPORT: busRdata[PORT_W-1:0] = pinSync & ~maskReg;
      IDX_PIN:   busRdata[PORT_W-1:0] = pinSync;
      IDX_SEL0, IDX_SEL1: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if ((c < 4) == (regIdx_e'(busAddr) == IDX_SEL0))
            busRdata[8*(c%4) +: SEL_W] = chSel[c];
        end
      end
      IDX_CFG: begin
        busRdata[NUM_CH-1:0]  = cfgEn;
        busRdata[8 +: NUM_CH]  = cfgLvl;
        busRdata[16 +: NUM_CH] = cfgPol;
      end
      IDX_STAT:  busRdata[NUM_CH-1:0] = statVec;
      default:   ;
    endcase
  end

  // Assertions
  a_r1_reset_outputs: assert property (@(posedge clk) !rstN |=> (pinOe == '0 && pinOut == '0 && !irq))
    else $error("R1: outputs not cleared by reset");

  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSet |=> ((pinOut & $past(wrW)) == $past(wrW)))
    else $error("R3: set write left a bit low");

  a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrClr |=> ((pinOut & $past(wrW)) == '0))
    else $error("R4: clear write left a bit high");

  a_r5_mport_protects: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMport |=> (((pinOut ^ $past(pinOut)) & $past(maskReg)) == '0))
    else $error("R5: masked bit changed by masked write");

  a_r10_edge_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(edgeStat) & ~$past(clrBits) & ~edgeStat) == '0))
    else $error("R10: edge status dropped without clear");

endmodule

// File: rtl/gpio_port_ctrl_top.sv
module gpio_port_ctrl_top
  import gpio_port_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [3:0]        busAddr,
  input  logic [31:0]       busWdata,
  input  logic [3:0]        busBe,
  output logic [31:0]       busRdata,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] pinOe,
  output logic [PORT_W-1:0] pinOut,
  output logic              irq
);

  wrStrobe_t stb;

  gpio_port_ctrl u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .busBe  (busBe),
    .stb    (stb)
  );

  gpio_port_dp #(.PORT_W(PORT_W), .NUM_CH(NUM_CH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .pinIn   (pinIn),
    .busRdata(busRdata),
    .pinOe   (pinOe),
    .pinOut  (pinOut),
    .irq     (irq)
  );

endmodule

// File: tb/gpio_port_ctrl_top_tb.sv
module gpio_port_ctrl_top_tb;

  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busRdata;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] pinOe, pinOut;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port_ctrl_top #(.PORT_W(W), .NUM_CH(8)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busBe(busBe), .busRdata(busRdata),
    .pinIn(pinIn), .pinOe(pinOe), .pinOut(pinOut), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] idx, input logic [31:0] data, input logic [3:0] be);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = idx; busWdata = data; busBe = be;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busBe = '0;
  endtask

  task automatic busRead(input logic [3:0] idx, output logic [31:0] data);
    @(negedge clk);
    busAddr = idx;
    #1 data = busRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    busRead(4'd0, d);  check("R1 dir", d, 0);
    busRead(4'd1, d);  check("R1 out", d, 0);
    busRead(4'd9, d);  check("R1 cfg", d, 0);
    check("R1 pinOe", {16'h0, pinOe}, 0);
    check("R1 irq", {31'h0, irq}, 0);
  endtask

  task automatic t_dir();
    logic [31:0] d;
    busWrite(4'd0, 32'h0000_00A5, 4'hF);
    #1 check("R2 pinOe", {16'h0, pinOe}, 32'h00A5);
    busWrite(4'd0, 32'h1234_FFFF, 4'hF);
    busRead(4'd0, d); check("R8 dir upper bits", d, 32'h0000_FFFF);
  endtask

  task automatic t_setClr();
    logic [31:0] d;
    busWrite(4'd1, 32'h0000_0F0F, 4'hF);
    busWrite(4'd2, 32'h0000_3000, 4'hF);
    busRead(4'd1, d); check("R3 set", d, 32'h3F0F);
    busRead(4'd2, d); check("R3 set reads 0", d, 0);
    busWrite(4'd3, 32'h0000_0003, 4'hF);
    busRead(4'd1, d); check("R4 clr", d, 32'h3F0C);
    check("R4 pinOut", {16'h0, pinOut}, 32'h3F0C);
    busRead(4'd3, d); check("R4 clr reads 0", d, 0);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    busWrite(4'd1, 32'hFFFF_FFFF, 4'b0001);
    busRead(4'd1, d); check("R6 low byte", d, 32'h3FFF);
    busWrite(4'd1, 32'h0000_0000, 4'b0010);
    busRead(4'd1, d); check("R6 high byte", d, 32'h00FF);
    busWrite(4'd2, 32'h0000_FF00, 4'b0001);
    busRead(4'd1, d); check("R6 set lane off", d, 32'h00FF);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    busWrite(4'd4, 32'h0000_FF00, 4'hF);
    busWrite(4'd5, 32'h0000_AAAA, 4'hF);
    busRead(4'd1, d); check("R5 masked write", d, 32'h00AA);
    pinIn = 16'h1234;
    settle();
    busRead(4'd5, d); check("R5 masked read", d, 32'h0034);
    busRead(4'd6, d); check("R7 pin read", d, 32'h1234);
    busRead(4'd1, d); check("R7 out independent", d, 32'h00AA);
    busWrite(4'd4, 32'h0000_0000, 4'hF);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    // R9: ch2 <- pin5 (index 7 byte 2), ch5 <- pin9 (index 8 byte 1), ch7 <- pin15 (index 8 byte 3)
    busWrite(4'd7, 32'h0005_0000, 4'hF);
    busWrite(4'd8, 32'h0F00_0900, 4'hF);
    busRead(4'd8, d); check("R9 selector readback", d, 32'h0F00_0900);
    pinIn = 16'h0200;
    settle();
    // enable ch2 (rising edge) and ch5 (falling edge)
    busWrite(4'd9, 32'h0004_0024, 4'hF);
    busWrite(4'd10, 32'h0000_00FF, 4'hF);
    busRead(4'd10, d); check("R10 cleared", d, 0);
    check("R12 irq idle", {31'h0, irq}, 0);
    pinIn = 16'h0220;
    settle();
    busRead(4'd10, d); check("R10 rising", d, 32'h04);
    check("R12 irq set", {31'h0, irq}, 1);
    pinIn = 16'h0200;
    settle();
    busRead(4'd10, d); check("R10 sticky", d, 32'h04);
    busWrite(4'd10, 32'h0000_0004, 4'hF);
    busRead(4'd10, d); check("R10 w1c", d, 0);
    check("R12 irq clear", {31'h0, irq}, 0);
    pinIn = 16'h0000;
    settle();
    busRead(4'd10, d); check("R10 falling", d, 32'h20);
    busWrite(4'd10, 32'h0000_00FF, 4'hF);
  endtask

  task automatic t_level();
    logic [31:0] d;
    // ch7 level, active high; ch0 (pin0) disabled
    busWrite(4'd9, 32'h0080_8080, 4'hF);
    pinIn = 16'h8001;
    settle();
    busRead(4'd10, d); check("R11 level high", d, 32'h80);
    check("R12 irq level", {31'h0, irq}, 1);
    pinIn = 16'h0000;
    settle();
    busRead(4'd10, d); check("R11 level low", d, 0);
    check("R11 disabled channel irq", {31'h0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_dir();
    t_setClr();
    t_lanes();
    t_mask();
    t_edge();
    t_level();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule